// File: doc/BRIEF.md
# Fuse Bank Register Front End

This block is the bus-facing register file of a one-time-programmable fuse bank. A simple 32-bit read/write bus reaches a control register (with OR-style and clear-style alias addresses), a timing register, a program data register and a window of shadow words that hold a copy of the fuse contents. Software reads fuse values from the shadow window. It burns fuses by writing a target address together with an unlock key into the control register and then writing the bit pattern to the data register. A separate program sequencer carries out the burn through a start/done handshake, and the fuse cells are modelled as a simple OR-able array.

The block protects selected words through two lock vectors, one for reads and one for writes. A violation sets a sticky error flag that freezes all further fuse and shadow traffic until software clears it. A reload request copies every fuse word into the shadows, one word per cycle, and the request bit drops by itself when the copy is done.

Top module: `fuse_bank_regif`

## Requirements
- R1: After reset, the control register reads 0, the timing register reads TIMING_RST (10), the data register reads 0, and every shadow word reads 0.
- R2: The control word reads as {unlock[31:16], 5'b0, reload bit 10, error bit 9, busy bit 8, target address [7:0]}, and it reads the same at offsets 0x000, 0x004 and 0x008. A write to 0x000 loads the address and unlock fields. A write to 0x004 ORs the written value into them, and a write to 0x008 clears the written bits. The timing register (bits [11:0]) is at 0x010 and the data register is at 0x020. Unmapped reads return 0.
- R3: Writing bit 10 as 1 through 0x000 or 0x004, while not busy and without an error, starts a reload. Reload and busy then read 1 for WORDS cycles while fuse word i is copied into shadow i, which is read at 0x400 + 0x10*i. After that, both bits clear by themselves.
- R4: A data write accepted while not busy always clears the unlock field. It starts a program only when the unlock field held 0x3E77 and no error was set.
- R5: A program keeps busy set for timing[11:0]+1 cycles and then ORs the data into the fuse word at the address latched at the start. Address writes during the burn have no effect on it. The shadows change only at the next reload.
- R6: A data write while busy is ignored: the data register and the unlock field keep their values.
- R7: A program request to a write-locked word, or to an address of WORDS or above, does not set busy and leaves the fuses unchanged. It sets error instead.
- R8: A read of a read-locked shadow word returns 0xBADABADA and sets error.
- R9: A shadow write changes the word when the word is not write-locked, no reload is running and no error is set. A shadow write to a write-locked word, or any shadow write during a reload, sets error and leaves the word unchanged.
- R10: While error is set, data writes start no program, reload requests are ignored, shadow writes are ignored and every shadow read returns 0xBADABADA. Error clears only by writing bit 9 to 0x008.
- R11: Fuse word i powers up as (i * 0x00010001) XOR 0x5A5A0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of a read |
| rlock_i | input | WORDS | Per-word read lock |
| wlock_i | input | WORDS | Per-word write/program lock |

## Verification
The bench attacks the unlock rule from both sides: a data write without the key, and a key left over from a write made during a burn. A design that kept the key alive would burn a second word. It writes the data register and retargets the address in the middle of a burn. A design without the latched address or the busy guard would burn the wrong word or change the pattern. It provokes each error source (a locked program target, an out-of-range target, a poison read, a locked shadow write and a shadow write during a reload) and then tries every kind of access while the error is set. A design whose error flag was not sticky would let a reload or a burn through. Finally, it checks that a burn stays invisible in the shadows until a reload, and that a reload overwrites software-written shadows.

// File: rtl/fuse_regif_pkg.sv
package fuse_regif_pkg;
  localparam logic [15:0] UNLOCK_KEY = 16'h3E77;
  localparam logic [31:0] POISON     = 32'hBADA_BADA;
  localparam logic [11:0] OFS_CTRL   = 12'h000;
  localparam logic [11:0] OFS_SET    = 12'h004;
  localparam logic [11:0] OFS_CLR    = 12'h008;
  localparam logic [11:0] OFS_TIMING = 12'h010;
  localparam logic [11:0] OFS_DATA   = 12'h020;
  localparam logic [11:0] OFS_WIN    = 12'h400;

  // power-up content of the fuse model
  function automatic logic [31:0] fuse_seed(int unsigned idx);
    return (32'(idx) * 32'h0001_0001) ^ 32'h5A5A_0000;
  endfunction
endpackage

// File: rtl/fuse_array_model.sv
module fuse_array_model import fuse_regif_pkg::*; #(
  parameter int WORDS = 128,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          prog_en_i,
  input  logic [AW-1:0] prog_idx_i,
  input  logic [31:0]   prog_bits_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic [31:0]   rd_word_o
);
  logic [31:0] cells [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) cells[i] <= fuse_seed(i);
    end else if (prog_en_i) begin
      cells[prog_idx_i] <= cells[prog_idx_i] | prog_bits_i;  // blown bits stay blown
    end
  end

  assign rd_word_o = cells[rd_idx_i];
endmodule

// File: rtl/fuse_prog_seq.sv
module fuse_prog_seq #(
  parameter int AW = 7,
  parameter int TW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] idx_i,
  input  logic [31:0]   bits_i,
  input  logic [TW-1:0] strobe_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] idx_o,
  output logic [31:0]   bits_o
);
  logic          active_q;
  logic [TW-1:0] cnt_q;
  logic [AW-1:0] idx_q;
  logic [31:0]   bits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      idx_q    <= '0;
      bits_q   <= '0;
    end else if (start_i && !active_q) begin
      active_q <= 1'b1;
      cnt_q    <= strobe_i;
      idx_q    <= idx_i;
      bits_q   <= bits_i;
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign busy_o = active_q;
  assign done_o = active_q && (cnt_q == '0);
  assign idx_o  = idx_q;
  assign bits_o = bits_q;

  // R5: no overlapping burns; done ends the burn
  p_no_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !active_q);
  p_done_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> !busy_o);
endmodule

// File: rtl/fuse_bank_regif.sv
module fuse_bank_regif import fuse_regif_pkg::*; #(
  parameter int          WORDS      = 128,
  parameter int          TW         = 12,
  parameter logic [11:0] TIMING_RST = 12'd10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [11:0]      addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic [WORDS-1:0] rlock_i,
  input  logic [WORDS-1:0] wlock_i
);
  localparam int AW = $clog2(WORDS);

  logic [7:0]    ctrl_addr_q;
  logic [15:0]   unlock_q;
  logic          err_q, rl_q;
  logic [AW-1:0] rl_idx_q;
  logic [TW-1:0] timing_q;
  logic [31:0]   data_q;
  logic [31:0]   shadow_q [WORDS];

  logic          seq_busy, seq_done;
  logic [AW-1:0] seq_idx;
  logic [31:0]   seq_bits, fuse_word;

  logic        busy, wr, rd;
  logic        wr_ctrl, wr_set, wr_clr, wr_tim, wr_data;
  logic [11:0] win_off;
  logic        win_hit, wr_win, rd_win;
  logic [AW-1:0] win_idx, tgt_idx;
  logic        tgt_ok, data_take, prog_try, prog_deny, prog_start, rl_start;
  logic        win_wr_ok, win_wr_bad, win_rd_bad;

  assign busy    = seq_busy | rl_q;
  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign wr_ctrl = wr && addr_i == OFS_CTRL;
  assign wr_set  = wr && addr_i == OFS_SET;
  assign wr_clr  = wr && addr_i == OFS_CLR;
  assign wr_tim  = wr && addr_i == OFS_TIMING;
  assign wr_data = wr && addr_i == OFS_DATA;

  assign win_off = addr_i - OFS_WIN;
  assign win_hit = addr_i >= OFS_WIN && win_off[3:0] == 4'h0 && 32'(win_off[11:4]) < WORDS;
  assign win_idx = win_off[AW+3:4];
  assign wr_win  = wr && win_hit;
  assign rd_win  = rd && win_hit;

  assign tgt_ok     = 32'(ctrl_addr_q) < WORDS;
  assign tgt_idx    = ctrl_addr_q[AW-1:0];
  assign data_take  = wr_data && !busy;
  assign prog_try   = data_take && !err_q && unlock_q == UNLOCK_KEY;
  assign prog_deny  = prog_try && (!tgt_ok || wlock_i[tgt_idx]);
  assign prog_start = prog_try && !prog_deny;
  assign rl_start   = (wr_ctrl || wr_set) && wdata_i[10] && !busy && !err_q;
  assign win_wr_ok  = wr_win && !err_q && !rl_q && !wlock_i[win_idx];
  assign win_wr_bad = wr_win && !err_q && (rl_q || wlock_i[win_idx]);
  assign win_rd_bad = rd_win && !err_q && rlock_i[win_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_addr_q <= '0;
      unlock_q    <= '0;
      err_q       <= 1'b0;
      timing_q    <= TIMING_RST[TW-1:0];
      data_q      <= '0;
    end else begin
      if (wr_ctrl)      ctrl_addr_q <= wdata_i[7:0];
      else if (wr_set)  ctrl_addr_q <= ctrl_addr_q | wdata_i[7:0];
      else if (wr_clr)  ctrl_addr_q <= ctrl_addr_q & ~wdata_i[7:0];

      if (data_take)    unlock_q <= '0;  // key is single-use
      else if (wr_ctrl) unlock_q <= wdata_i[31:16];
      else if (wr_set)  unlock_q <= unlock_q | wdata_i[31:16];
      else if (wr_clr)  unlock_q <= unlock_q & ~wdata_i[31:16];

      if (prog_deny || win_wr_bad || win_rd_bad) err_q <= 1'b1;
      else if (wr_clr && wdata_i[9])             err_q <= 1'b0;

      if (wr_tim)    timing_q <= wdata_i[TW-1:0];
      if (data_take) data_q   <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rl_q     <= 1'b0;
      rl_idx_q <= '0;
      for (int i = 0; i < WORDS; i++) shadow_q[i] <= '0;
    end else begin
      if (rl_start) begin
        rl_q     <= 1'b1;
        rl_idx_q <= '0;
      end else if (rl_q) begin
        shadow_q[rl_idx_q] <= fuse_word;
        rl_idx_q           <= rl_idx_q + 1'b1;
        if (rl_idx_q == AW'(WORDS - 1)) rl_q <= 1'b0;
      end
      if (win_wr_ok) shadow_q[win_idx] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (addr_i)
        OFS_CTRL, OFS_SET, OFS_CLR:
          rdata_o = {unlock_q, 5'b0, rl_q, err_q, busy, ctrl_addr_q};
        OFS_TIMING: rdata_o = 32'(timing_q);
        OFS_DATA:   rdata_o = data_q;
        default:
          if (win_hit) rdata_o = (err_q || rlock_i[win_idx]) ? POISON : shadow_q[win_idx];
      endcase
    end
  end

  fuse_prog_seq #(.AW(AW), .TW(TW)) u_seq (
    .clk_i, .rst_ni,
    .start_i (prog_start),
    .idx_i   (tgt_idx),
    .bits_i  (wdata_i),
    .strobe_i(timing_q),
    .busy_o  (seq_busy),
    .done_o  (seq_done),
    .idx_o   (seq_idx),
    .bits_o  (seq_bits)
  );

  fuse_array_model #(.WORDS(WORDS)) u_fuse (
    .clk_i, .rst_ni,
    .prog_en_i  (seq_done),
    .prog_idx_i (seq_idx),
    .prog_bits_i(seq_bits),
    .rd_idx_i   (rl_idx_q),
    .rd_word_o  (fuse_word)
  );

  p_unlock_spent_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_take |=> unlock_q == '0);
  p_data_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data && busy |=> $stable(data_q));
  p_deny_no_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_deny |=> err_q && !seq_busy);
  p_poison_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_rd_bad |=> err_q);
  p_reload_ends_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rl_q && rl_idx_q == AW'(WORDS - 1) |=> !rl_q);
  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q && !(wr_clr && wdata_i[9]) |=> err_q);
endmodule

// File: tb/fuse_bank_regif_tb_top.sv
module fuse_bank_regif_tb_top;
  localparam int W = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [W-1:0] rlock, wlock;

  always #2 clk = ~clk;  // 250 MHz

  fuse_bank_regif dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rlock_i(rlock), .wlock_i(wlock)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // behavioural reference state
  logic [31:0] m_fuse [W];
  logic [31:0] m_sh [W];
  logic [7:0]  m_addr;
  logic [15:0] m_unl;
  logic [11:0] m_tim;
  logic [31:0] m_data, m_pbits;
  bit m_err, m_rl, m_pact;
  int m_ridx, m_pleft, m_paddr;

  function automatic logic [31:0] seed(int i);
    return (32'(i) * 32'h0001_0001) ^ 32'h5A5A_0000;
  endfunction

  function automatic bit in_win(logic [11:0] a);
    return a >= 12'h400 && ((int'(a) - 'h400) % 16) == 0 && ((int'(a) - 'h400) / 16) < W;
  endfunction

  function automatic logic [31:0] m_read(logic [11:0] a);
    int i;
    if (a == 12'h000 || a == 12'h004 || a == 12'h008)
      return {m_unl, 5'b0, m_rl, m_err, (m_pact || m_rl), m_addr};
    if (a == 12'h010) return {20'h0, m_tim};
    if (a == 12'h020) return m_data;
    if (in_win(a)) begin
      i = (int'(a) - 'h400) / 16;
      return (m_err || rlock[i]) ? 32'hBADA_BADA : m_sh[i];
    end
    return 32'h0;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < W; i++) begin m_fuse[i] = seed(i); m_sh[i] = '0; end
    m_addr = 0; m_unl = 0; m_tim = 12'd10; m_data = 0; m_pbits = 0;
    m_err = 0; m_rl = 0; m_pact = 0; m_ridx = 0; m_pleft = 0; m_paddr = 0;
  endtask

  task automatic m_edge(logic w, logic [11:0] a, logic [31:0] d);
    bit busy0 = m_pact || m_rl, err0 = m_err, rl0 = m_rl;
    logic [15:0] unl0 = m_unl;
    int tgt = m_addr, wi = (int'(a) - 'h400) / 16;
    if (rl0) begin
      m_sh[m_ridx] = m_fuse[m_ridx];
      if (m_ridx == W - 1) begin m_rl = 0; m_ridx = 0; end else m_ridx++;
    end
    if (m_pact) begin
      if (m_pleft == 0) begin m_fuse[m_paddr] |= m_pbits; m_pact = 0; end
      else m_pleft--;
    end
    if (w) begin
      if (a == 12'h000) begin
        m_addr = d[7:0]; m_unl = d[31:16];
        if (d[10] && !busy0 && !err0) begin m_rl = 1; m_ridx = 0; end
      end else if (a == 12'h004) begin
        m_addr |= d[7:0]; m_unl |= d[31:16];
        if (d[10] && !busy0 && !err0) begin m_rl = 1; m_ridx = 0; end
      end else if (a == 12'h008) begin
        m_addr &= ~d[7:0]; m_unl &= ~d[31:16];
        if (d[9]) m_err = 0;
      end else if (a == 12'h010) m_tim = d[11:0];
      else if (a == 12'h020) begin
        if (!busy0) begin
          m_data = d; m_unl = 0;
          if (!err0 && unl0 == 16'h3E77) begin
            if (tgt >= W || wlock[tgt]) m_err = 1;
            else begin m_pact = 1; m_pleft = m_tim; m_paddr = tgt; m_pbits = d; end
          end
        end
      end else if (in_win(a) && !err0) begin
        if (rl0 || wlock[wi]) m_err = 1; else m_sh[wi] = d;
      end
    end else if (in_win(a) && !err0 && rlock[wi]) m_err = 1;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, addr, act, exp);
    end
  endtask

  // one bus cycle, compared against the model every clock
  task automatic step(logic w, logic [11:0] a, logic [31:0] d, string tag);
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d;
    #1 check(tag, rdata, w ? 32'h0 : m_read(a));
    @(posedge clk);
    m_edge(w, a, d);
  endtask

  task automatic peek(logic [11:0] a, logic [31:0] lit, string tag);
    @(negedge clk);
    req = 1; we = 0; addr = a; wdata = 0;
    #1 check(tag, rdata, m_read(a));
    check(tag, rdata, lit);
    @(posedge clk);
    m_edge(0, a, 0);
  endtask

  task automatic idle(int n, string tag);
    for (int k = 0; k < n; k++) step(0, 12'h000, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rlock = '0; rlock[5] = 1; rlock[20] = 1;
    wlock = '0; wlock[7] = 1; wlock[9] = 1;
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    peek(12'h000, 32'h0, "R1");
    peek(12'h010, 32'd10, "R1");
    peek(12'h020, 32'h0, "R1");
    peek(12'h400, 32'h0, "R1");
    peek(12'h0C0, 32'h0, "R2");
    // R2 timing
    step(1, 12'h010, 32'h0000_0003, "R2");
    peek(12'h010, 32'd3, "R2");
    // R3 reload via set alias
    step(1, 12'h004, 32'h0000_0400, "R3");
    peek(12'h000, 32'h0000_0500, "R3");
    idle(140, "R3");
    peek(12'h000, 32'h0, "R3");
    peek(12'h400, seed(0), "R11");
    peek(12'hBF0, seed(127), "R11");
    // R4/R5/R6 program word 3
    step(1, 12'h000, 32'h3E77_0003, "R2");
    peek(12'h008, 32'h3E77_0003, "R2");
    step(1, 12'h020, 32'h0000_00F0, "R4");
    peek(12'h000, 32'h0000_0103, "R4");
    step(1, 12'h000, 32'h3E77_0004, "R5");
    step(1, 12'h020, 32'h0000_FFFF, "R6");
    peek(12'h020, 32'h0000_00F0, "R6");
    peek(12'h004, 32'h3E77_0004, "R6");
    idle(6, "R5");
    peek(12'h430, seed(3), "R5");
    step(1, 12'h008, 32'hFFFF_FFFF, "R2");
    peek(12'h000, 32'h0, "R2");
    step(1, 12'h004, 32'h0000_0400, "R3");
    idle(140, "R3");
    peek(12'h430, seed(3) | 32'hF0, "R5");
    peek(12'h440, seed(4), "R5");
    // R2 aliases
    step(1, 12'h004, 32'h0000_0012, "R2");
    step(1, 12'h004, 32'h0000_0021, "R2");
    peek(12'h000, 32'h0000_0033, "R2");
    step(1, 12'h008, 32'h0000_0011, "R2");
    peek(12'h000, 32'h0000_0022, "R2");
    // R4 no key: nothing starts
    step(1, 12'h020, 32'h0000_0001, "R4");
    peek(12'h000, 32'h0000_0022, "R4");
    // R7 locked target, R10 error blocks
    step(1, 12'h000, 32'h3E77_0007, "R7");
    step(1, 12'h020, 32'h0000_00FF, "R7");
    peek(12'h000, 32'h0000_0207, "R7");
    step(1, 12'h000, 32'h3E77_0008, "R10");
    step(1, 12'h020, 32'h0000_0001, "R10");
    peek(12'h000, 32'h0000_0208, "R10");
    step(1, 12'h004, 32'h0000_0400, "R10");
    peek(12'h000, 32'h0000_0208, "R10");
    peek(12'h400, 32'hBADA_BADA, "R10");
    step(1, 12'h4B0, 32'h0000_ABCD, "R10");
    step(1, 12'h008, 32'h0000_0200, "R10");
    peek(12'h000, 32'h0000_0008, "R10");
    peek(12'h4B0, seed(11), "R10");
    // R7 out-of-range target
    step(1, 12'h000, 32'h3E77_0090, "R7");
    step(1, 12'h020, 32'h0000_0001, "R7");
    peek(12'h000, 32'h0000_0290, "R7");
    step(1, 12'h008, 32'hFFFF_FFFF, "R7");
    // R8 poison read
    peek(12'h450, 32'hBADA_BADA, "R8");
    peek(12'h000, 32'h0000_0200, "R8");
    step(1, 12'h008, 32'h0000_0200, "R8");
    // R9 shadow writes
    step(1, 12'h4A0, 32'h0000_1234, "R9");
    peek(12'h4A0, 32'h0000_1234, "R9");
    step(1, 12'h490, 32'h0000_0055, "R9");
    peek(12'h000, 32'h0000_0200, "R9");
    step(1, 12'h008, 32'h0000_0200, "R9");
    peek(12'h490, seed(9), "R9");
    step(1, 12'h004, 32'h0000_0400, "R9");
    step(1, 12'h4C0, 32'h0000_7777, "R9");
    peek(12'h000, 32'h0000_0700, "R9");
    idle(140, "R9");
    peek(12'h000, 32'h0000_0200, "R9");
    step(1, 12'h008, 32'h0000_0200, "R9");
    peek(12'h4A0, seed(10), "R9");
    peek(12'h4C0, seed(12), "R9");
    peek(12'h430, seed(3) | 32'hF0, "R5");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule